// File: doc/BRIEF.md
# Strided Vector Memory Access Sequencer

This block turns one vector load or store instruction into a stream of element accesses to an interleaved, pipelined memory. Scalar writes set two configuration registers: the element count and the stride between consecutive elements. The instruction itself supplies only the base address and the direction.

Once an instruction is accepted, the block clears its element index. It then issues one request per cycle, advancing the index and adding the stride to a running address. It stops when the remaining count reaches zero. Because the bank select is taken from the low address bits, a unit stride walks across all banks. A bank can therefore start a new access every cycle, provided the bank count is at least the memory latency.

For loads, the memory answers a fixed number of cycles after each request. The block carries the element number of every request through a delay line of that depth. This lets each returning word be written into the vector register at the right element. Loops longer than the maximum vector length are strip-mined by software: it issues a second instruction whose base is advanced by the first strip's length.

Top module: `vstride_seq`

## Requirements
- R1: After reset, cmd_ready is 1 and mem_req_valid, wb_valid and done are 0. The count register holds MAX_VL (64) and the stride register holds 1, so an unconfigured instruction moves 64 unit-stride elements.
- R2: A count write above MAX_VL stores MAX_VL. An accepted instruction with count N>0 issues exactly N requests, in the N consecutive cycles that start the cycle after acceptance.
- R3: The request for element i (i = 0 .. N-1) carries mem_req_idx = i and mem_req_addr = base + i*stride, modulo 2^ADDR_W. A stride above 2^(ADDR_W-1) therefore acts as a negative step. mem_req_bank carries the low BANK_BITS (6) bits of that address.
- R4: The count and stride in effect are the ones held when the instruction is accepted. Configuration writes made while an instruction runs change only later instructions.
- R5: For a load, element i is written back in cycle acceptance+1+i+LAT (LAT = 11), with wb_idx = i and wb_data equal to mem_rsp_data of that cycle. The memory presents the data of a request issued in cycle t during cycle t+LAT.
- R6: For a store, every request has mem_req_we = 1 and mem_req_wdata equal to st_rd_data, which is read at element mem_req_idx. No write-back occurs. Loads issue with mem_req_we = 0.
- R7: done is a one-cycle pulse. For a load it rises the cycle after the last write-back. For a store it rises the cycle after the last request. For a count of 0 it rises the cycle after acceptance, and no request is issued.
- R8: cmd_ready is 0 from the cycle after acceptance until the cycle done rises, where it returns to 1. A command presented while cmd_ready is 0 is not taken and does not alter the running instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_vl_we | input | 1 | Write strobe for the element count register |
| cfg_vl_val | input | IDX_W (7) | New element count, saturated to MAX_VL |
| cfg_stride_we | input | 1 | Write strobe for the stride register |
| cfg_stride_val | input | ADDR_W (16) | New stride in address units |
| cmd_valid | input | 1 | Instruction request |
| cmd_ready | output | 1 | Sequencer idle, instruction can be taken |
| cmd_store | input | 1 | 1 = store, 0 = load |
| cmd_base | input | ADDR_W | Base address of element 0 |
| mem_req_valid | output | 1 | Element request this cycle |
| mem_req_we | output | 1 | Request is a write |
| mem_req_addr | output | ADDR_W | Element address |
| mem_req_bank | output | BANK_BITS (6) | Bank select |
| mem_req_idx | output | IDX_W | Element number of the request |
| mem_req_wdata | output | DATA_W (16) | Store data |
| st_rd_data | input | DATA_W | Vector register data of element mem_req_idx |
| mem_rsp_data | input | DATA_W | Read data returned by memory |
| wb_valid | output | 1 | Write an element into the vector register |
| wb_idx | output | IDX_W | Element number to write |
| wb_data | output | DATA_W | Data to write |
| done | output | 1 | Instruction complete pulse |

## Verification
On every cycle, the checker verifies the shape of the request stream. The index starts at zero and rises by one per request, and stays below the maximum length. The address step stays constant within a stream, and the direction does not change mid-stream. It also checks that write-backs come in element order, that none appear while a store is issuing, that requests never overlap readiness, and that done lasts one cycle. Several properties need the bench's scenarios instead: the absolute addresses and bank bits, and the exact eleven-cycle return timing with matching data. The same holds for count saturation, the latching of configuration against writes made mid-instruction, and a held-off command that leaves the running stream untouched.

// File: rtl/vstride_pkg.sv
package vstride_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_DRAIN = 2'd2
   } seq_state_e;
endpackage

// File: rtl/vstride_index.sv
// Element index with clear and step controls, plus remaining-count zero detect.
module vstride_index #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             idx_clear,
   input  logic             idx_step,
   input  logic [CNT_W-1:0] count_in,
   output logic [CNT_W-1:0] idx,
   output logic             last_elem
);
   logic [CNT_W-1:0] idx_q;
   logic [CNT_W-1:0] rem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         rem_q <= '0;
      end else if (idx_clear) begin
         idx_q <= '0;
         rem_q <= count_in;
      end else if (idx_step) begin
         idx_q <= idx_q + 1'b1;
         rem_q <= rem_q - 1'b1;
      end
   end

   assign idx       = idx_q;
   // one element left: this step drives the remaining count to zero
   assign last_elem = (rem_q == CNT_W'(1));
endmodule

// File: rtl/vstride_agen.sv
// Running address: base on start, plus latched stride on every step.
module vstride_agen #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              step,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] stride,
   output logic [ADDR_W-1:0] addr
);
   logic [ADDR_W-1:0] acc_q;
   logic [ADDR_W-1:0] stride_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q    <= '0;
         stride_q <= '0;
      end else if (start) begin
         acc_q    <= base;
         stride_q <= stride;
      end else if (step) begin
         acc_q    <= acc_q + stride_q;
      end
   end

   assign addr = acc_q;
endmodule

// File: rtl/vstride_lat_track.sv
// Fixed-depth delay line carrying element number and last flag of each load.
module vstride_lat_track #(
   parameter int LAT   = 11,
   parameter int IDX_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_last,
   input  logic [IDX_W-1:0] in_idx,
   output logic             out_valid,
   output logic             out_last,
   output logic [IDX_W-1:0] out_idx
);
   logic [LAT-1:0]            v_q;
   logic [LAT-1:0]            l_q;
   logic [LAT-1:0][IDX_W-1:0] i_q;

   if (LAT == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= '0;
            l_q <= '0;
            i_q <= '0;
         end else begin
            v_q <= in_valid;
            l_q <= in_last;
            i_q <= in_idx;
         end
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= '0;
            l_q <= '0;
            i_q <= '0;
         end else begin
            v_q <= {v_q[LAT-2:0], in_valid};
            l_q <= {l_q[LAT-2:0], in_last};
            i_q <= {i_q[LAT-2:0], in_idx};
         end
      end
   end

   assign out_valid = v_q[LAT-1];
   assign out_last  = l_q[LAT-1];
   assign out_idx   = i_q[LAT-1];
endmodule

// File: rtl/vstride_seq.sv
module vstride_seq
   import vstride_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 16,
   parameter int MAX_VL    = 64,
   parameter int LAT       = 11,
   parameter int BANK_BITS = 6,
   localparam int IDX_W    = $clog2(MAX_VL + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_vl_we,
   input  logic [IDX_W-1:0]  cfg_vl_val,
   input  logic              cfg_stride_we,
   input  logic [ADDR_W-1:0] cfg_stride_val,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic              cmd_store,
   input  logic [ADDR_W-1:0] cmd_base,
   output logic              mem_req_valid,
   output logic              mem_req_we,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [BANK_BITS-1:0] mem_req_bank,
   output logic [IDX_W-1:0]  mem_req_idx,
   output logic [DATA_W-1:0] mem_req_wdata,
   input  logic [DATA_W-1:0] st_rd_data,
   input  logic [DATA_W-1:0] mem_rsp_data,
   output logic              wb_valid,
   output logic [IDX_W-1:0]  wb_idx,
   output logic [DATA_W-1:0] wb_data,
   output logic              done
);
   localparam int BANKS = 1 << BANK_BITS;
   localparam logic [IDX_W-1:0] VL_MAX = IDX_W'(MAX_VL);

   if (MAX_VL < 1) begin : g_bad_vl
      $error("vstride_seq: MAX_VL must be at least 1");
   end
   if (LAT < 1) begin : g_bad_lat
      $error("vstride_seq: LAT must be at least 1");
   end
   if (BANK_BITS < 1 || BANK_BITS > ADDR_W) begin : g_bad_bank_w
      $error("vstride_seq: BANK_BITS must lie in 1..ADDR_W");
   end
   if (BANKS < LAT) begin : g_bad_banks
      $error("vstride_seq: bank count must cover the memory latency");
   end

   seq_state_e        state_q;
   logic              store_q;
   logic              done_q;
   logic [IDX_W-1:0]  vl_q;
   logic [ADDR_W-1:0] stride_q;
   logic              accept;
   logic              issuing;
   logic              last_elem;
   logic [IDX_W-1:0]  cur_idx;
   logic [ADDR_W-1:0] cur_addr;
   logic              trk_valid;
   logic              trk_last;
   logic [IDX_W-1:0]  trk_idx;

   // configuration registers written by scalar instructions
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vl_q     <= VL_MAX;
         stride_q <= ADDR_W'(1);
      end else begin
         if (cfg_vl_we)
            vl_q <= (cfg_vl_val > VL_MAX) ? VL_MAX : cfg_vl_val;
         if (cfg_stride_we)
            stride_q <= cfg_stride_val;
      end
   end

   assign cmd_ready = (state_q == ST_IDLE);
   assign accept    = cmd_valid && cmd_ready;
   assign issuing   = (state_q == ST_ISSUE);

   vstride_index #(.CNT_W(IDX_W)) u_index (
      .clk       (clk),
      .rst_n     (rst_n),
      .idx_clear (accept),
      .idx_step  (issuing),
      .count_in  (vl_q),
      .idx       (cur_idx),
      .last_elem (last_elem)
   );

   vstride_agen #(.ADDR_W(ADDR_W)) u_agen (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (accept),
      .step   (issuing),
      .base   (cmd_base),
      .stride (stride_q),
      .addr   (cur_addr)
   );

   vstride_lat_track #(.LAT(LAT), .IDX_W(IDX_W)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (issuing && !store_q),
      .in_last   (last_elem),
      .in_idx    (cur_idx),
      .out_valid (trk_valid),
      .out_last  (trk_last),
      .out_idx   (trk_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         store_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  store_q <= cmd_store;
                  if (vl_q == '0) done_q  <= 1'b1;
                  else            state_q <= ST_ISSUE;
               end
            end
            ST_ISSUE: begin
               if (last_elem) begin
                  if (store_q) begin
                     done_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end else begin
                     state_q <= ST_DRAIN;
                  end
               end
            end
            ST_DRAIN: begin
               if (trk_valid && trk_last) begin
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_req_valid = issuing;
   assign mem_req_we    = issuing && store_q;
   assign mem_req_addr  = cur_addr;
   assign mem_req_bank  = cur_addr[BANK_BITS-1:0];
   assign mem_req_idx   = cur_idx;
   assign mem_req_wdata = store_q ? st_rd_data : '0;
   assign wb_valid      = trk_valid;
   assign wb_idx        = trk_idx;
   assign wb_data       = mem_rsp_data;
   assign done          = done_q;
endmodule

// File: rtl/vstride_seq_chk.sv
module vstride_seq_chk #(
   parameter int ADDR_W = 16,
   parameter int IDX_W  = 7,
   parameter int MAX_VL = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_ready,
   input logic              mem_req_valid,
   input logic              mem_req_we,
   input logic [ADDR_W-1:0] mem_req_addr,
   input logic [IDX_W-1:0]  mem_req_idx,
   input logic              wb_valid,
   input logic [IDX_W-1:0]  wb_idx,
   input logic              done
);
   p_first_idx_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !$past(mem_req_valid) |-> mem_req_idx == '0)
      else $error("first element index not zero");

   p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && $past(mem_req_valid) |-> mem_req_idx == IDX_W'($past(mem_req_idx) + 1'b1))
      else $error("index did not advance by one");

   p_idx_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> int'(mem_req_idx) < MAX_VL)
      else $error("index beyond maximum length");

   p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && $past(mem_req_valid) && $past(mem_req_valid, 2) |->
         ADDR_W'(mem_req_addr - $past(mem_req_addr)) == ADDR_W'($past(mem_req_addr) - $past(mem_req_addr, 2)))
      else $error("address step changed within a stream");

   p_dir_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && $past(mem_req_valid) |-> $stable(mem_req_we))
      else $error("direction changed within a stream");

   p_no_wb_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_we |-> !wb_valid)
      else $error("write-back during a store");

   p_wb_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid && $past(wb_valid) |-> wb_idx == IDX_W'($past(wb_idx) + 1'b1))
      else $error("write-back out of element order");

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done)
      else $error("done longer than one cycle");

   p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !cmd_ready)
      else $error("ready while issuing");
endmodule

bind vstride_seq vstride_seq_chk #(
   .ADDR_W (ADDR_W),
   .IDX_W  (IDX_W),
   .MAX_VL (MAX_VL)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cmd_ready     (cmd_ready),
   .mem_req_valid (mem_req_valid),
   .mem_req_we    (mem_req_we),
   .mem_req_addr  (mem_req_addr),
   .mem_req_idx   (mem_req_idx),
   .wb_valid      (wb_valid),
   .wb_idx        (wb_idx),
   .done          (done)
);

// File: tb/vstride_seq_tb.sv
`timescale 1ns/1ps
module vstride_seq_tb_top;
   localparam int ADDR_W = 16;
   localparam int DATA_W = 16;
   localparam int MAX_VL = 64;
   localparam int LAT    = 11;
   localparam int BANK_BITS = 6;
   localparam int IDX_W  = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_vl_we = 1'b0;
   logic [IDX_W-1:0] cfg_vl_val = '0;
   logic cfg_stride_we = 1'b0;
   logic [ADDR_W-1:0] cfg_stride_val = '0;
   logic cmd_valid = 1'b0;
   logic cmd_ready;
   logic cmd_store = 1'b0;
   logic [ADDR_W-1:0] cmd_base = '0;
   logic mem_req_valid, mem_req_we;
   logic [ADDR_W-1:0] mem_req_addr;
   logic [BANK_BITS-1:0] mem_req_bank;
   logic [IDX_W-1:0] mem_req_idx;
   logic [DATA_W-1:0] mem_req_wdata;
   logic [DATA_W-1:0] st_rd_data;
   logic [DATA_W-1:0] mem_rsp_data;
   logic wb_valid;
   logic [IDX_W-1:0] wb_idx;
   logic [DATA_W-1:0] wb_data;
   logic done;

   int tests = 0;
   int fails = 0;
   int m_vl = MAX_VL;
   logic [ADDR_W-1:0] m_st = 16'd1;

   always #2 clk = ~clk;

   function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
      return 16'(a * 16'h9E37 + 16'h1234);
   endfunction

   function automatic logic [DATA_W-1:0] vreg_word(input logic [IDX_W-1:0] i);
      return 16'(16'hC000 ^ (i * 16'd7));
   endfunction

   function automatic logic [ADDR_W-1:0] elem_addr(input logic [ADDR_W-1:0] b,
                                                   input int i, input logic [ADDR_W-1:0] s);
      return 16'(b + i * s);
   endfunction

   // memory model: data of the request seen in cycle t is presented in cycle t+LAT
   logic [ADDR_W-1:0] mpipe [LAT];
   always_ff @(posedge clk) begin
      mpipe[0] <= mem_req_addr;
      for (int k = 1; k < LAT; k++) mpipe[k] <= mpipe[k-1];
   end
   assign mem_rsp_data = mem_word(mpipe[LAT-1]);
   assign st_rd_data   = vreg_word(mem_req_idx);

   vstride_seq dut_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_vl_we(cfg_vl_we), .cfg_vl_val(cfg_vl_val),
      .cfg_stride_we(cfg_stride_we), .cfg_stride_val(cfg_stride_val),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_store(cmd_store), .cmd_base(cmd_base),
      .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
      .mem_req_bank(mem_req_bank), .mem_req_idx(mem_req_idx), .mem_req_wdata(mem_req_wdata),
      .st_rd_data(st_rd_data), .mem_rsp_data(mem_rsp_data),
      .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data), .done(done)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cfg(input int vl, input logic [ADDR_W-1:0] st);
      @(negedge clk);
      cfg_vl_we = 1'b1; cfg_vl_val = IDX_W'(vl);
      cfg_stride_we = 1'b1; cfg_stride_val = st;
      @(negedge clk);
      cfg_vl_we = 1'b0; cfg_stride_we = 1'b0;
      m_vl = (vl > MAX_VL) ? MAX_VL : vl;   // R2 saturation
      m_st = st;
   endtask

   task automatic run_cmd(input logic st, input logic [ADDR_W-1:0] base,
                          input bit hold, input bit midcfg);
      int n = m_vl;
      logic [ADDR_W-1:0] s = m_st;
      int dc;
      dc = (n == 0) ? 1 : (st ? n + 1 : n + LAT + 1);
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_valid = 1'b1; cmd_store = st; cmd_base = base;
      @(posedge clk);
      for (int c = 1; c <= dc + 1; c++) begin
         @(negedge clk);
         if (c <= n) begin
            logic [ADDR_W-1:0] ea;
            ea = elem_addr(base, c - 1, s);
            chk(mem_req_valid === 1'b1, "R2 request valid", int'(mem_req_valid), 1);
            chk(mem_req_addr === ea, hold ? "R8 addr under hold-off" :
                (midcfg ? "R4 addr under cfg write" : "R3 address"), int'(mem_req_addr), int'(ea));
            chk(mem_req_idx === IDX_W'(c - 1), "R3 index", int'(mem_req_idx), c - 1);
            chk(mem_req_bank === ea[BANK_BITS-1:0], "R3 bank", int'(mem_req_bank), int'(ea[BANK_BITS-1:0]));
            chk(mem_req_we === st, "R6 write enable", int'(mem_req_we), int'(st));
            if (st)
               chk(mem_req_wdata === vreg_word(IDX_W'(c - 1)), "R6 store data",
                   int'(mem_req_wdata), int'(vreg_word(IDX_W'(c - 1))));
         end else begin
            chk(mem_req_valid === 1'b0, "R2 no extra request", int'(mem_req_valid), 0);
         end
         if (!st && c >= LAT + 1 && c <= LAT + n) begin
            int j = c - LAT - 1;
            logic [DATA_W-1:0] ed;
            ed = mem_word(elem_addr(base, j, s));
            chk(wb_valid === 1'b1, "R5 write-back valid", int'(wb_valid), 1);
            chk(wb_idx === IDX_W'(j), "R5 write-back index", int'(wb_idx), j);
            chk(wb_data === ed, "R5 write-back data", int'(wb_data), int'(ed));
         end else begin
            chk(wb_valid === 1'b0, st ? "R6 no store write-back" : "R5 no write-back",
                int'(wb_valid), 0);
         end
         chk(done === (c == dc), "R7 done timing", int'(done), int'(c == dc));
         chk(cmd_ready === (c >= dc), "R8 ready", int'(cmd_ready), int'(c >= dc));
         // drives after the checks of this cycle
         if (c == 1) begin
            if (hold) cmd_base = ~base;
            else      cmd_valid = 1'b0;
         end
         if (c == 3 && hold) cmd_valid = 1'b0;
         if (c == 2 && midcfg) begin
            cfg_vl_we = 1'b1; cfg_vl_val = 7'd5;
            cfg_stride_we = 1'b1; cfg_stride_val = 16'd3;
            m_vl = 5; m_st = 16'd3;
         end
         if (c == 3 && midcfg) begin
            cfg_vl_we = 1'b0; cfg_stride_we = 1'b0;
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(cmd_ready === 1'b1, "R1 ready after reset", int'(cmd_ready), 1);
      chk(mem_req_valid === 1'b0, "R1 no request after reset", int'(mem_req_valid), 0);
      chk(wb_valid === 1'b0, "R1 no write-back after reset", int'(wb_valid), 0);
      chk(done === 1'b0, "R1 done low after reset", int'(done), 0);
      rst_n = 1'b1;
      // R1 default count 64, stride 1
      run_cmd(1'b0, 16'h0000, 1'b0, 1'b0);
      // strip-mined 64 + 36
      cfg(64, 16'd1);
      run_cmd(1'b0, 16'h0100, 1'b0, 1'b0);
      cfg(36, 16'd1);
      run_cmd(1'b1, 16'h0140, 1'b0, 1'b0);
      // strip-mined 50 + 50
      cfg(50, 16'd1);
      run_cmd(1'b0, 16'h2000, 1'b0, 1'b0);
      run_cmd(1'b0, 16'h2032, 1'b0, 1'b0);
      // empty and single-element instructions
      cfg(0, 16'd1);
      run_cmd(1'b0, 16'h3000, 1'b0, 1'b0);
      run_cmd(1'b1, 16'h3000, 1'b0, 1'b0);
      cfg(1, 16'd5);
      run_cmd(1'b0, 16'h3100, 1'b0, 1'b0);
      run_cmd(1'b1, 16'h3100, 1'b0, 1'b0);
      // R2 saturation with a negative stride, R8 hold-off
      cfg(100, 16'hFFFD);
      run_cmd(1'b0, 16'h0010, 1'b1, 1'b0);
      // R4 configuration written mid-instruction, then used by the next one
      cfg(20, 16'd2);
      run_cmd(1'b1, 16'h4000, 1'b0, 1'b1);
      run_cmd(1'b0, 16'h4100, 1'b0, 1'b0);
      // constrained random mix
      for (int k = 0; k < 16; k++) begin
         int vl = $urandom_range(0, 72);
         int mode = $urandom_range(0, 2);
         logic [ADDR_W-1:0] st;
         st = (mode == 0) ? 16'd1 : (mode == 1) ? 16'($urandom) : 16'(-$urandom_range(1, 9));
         cfg(vl, st);
         run_cmd(1'($urandom_range(0, 1)), 16'($urandom), 1'b0, 1'b0);
      end
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule